// File: doc/BRIEF.md
# Serial Shift Unit for a 16-bit Accumulator Machine

This block carries out the shift-class instructions of a 16-bit accumulator machine. It takes the instruction word, the accumulator A, the extension register B and the carry flag C, all sampled on a start strobe. It then shifts one bit position per clock. When the count is used up it pulses a done strobe and holds the new A, B and C until the next start. The shifted operand is either A alone (16 bits) or the pair A:B (32 bits, with A as the high half). Each shift is logical, arithmetic or rotate, to the left or to the right.

The unit decodes the function field and the shift count on its own. The shift count is held in the instruction as a two's complement number of positions, so the number of clocks a shift takes depends on the instruction alone. Fetching instructions and writing results back to the register file belong to the surrounding datapath.

Top module: `shift_unit`

## Requirements
- R1: The function code is bits 15..6 of `instr` and the count field is bits 5..0. The legal codes, in octal, are 0400–0402 and 0404–0406 (right) and 0410–0412 and 0414–0416 (left). In these codes, bit 3 of the function selects left (1) or right (0), bit 2 selects single A (1) or long A:B (0), and bits 1..0 select logical (0), arithmetic (1) or rotate (2).
- R2: The shift amount is (64 − count) mod 64, and a count of 0 means 64 positions. With start accepted at clock edge 0, `done` is high for the cycle that follows edge N, where N is the amount.
- R3: `done` is a single-cycle pulse and is never high together with `busy`. After `done`, the outputs hold their values until the next start is accepted.
- R4: While `busy` is high, `start` is ignored. The running shift finishes with its original operands and amount.
- R5: Logical shifts fill the vacated positions with 0 and leave the last bit shifted out in C.
- R6: An arithmetic right shift fills from bit 15 of A, which is the sign bit in both single and long forms, and leaves the last bit shifted out in C.
- R7: An arithmetic left shift fills with 0. C is cleared at start and is set if the sign bit (bit 15 of A) changes at any step.
- R8: Rotates move bits circularly through the 16-bit or 32-bit operand and leave C at its start value.
- R9: Long forms treat A:B as one 32-bit value with A high. Single forms leave B unchanged.
- R10: An illegal function code raises `done` in the cycle after start and returns A, B and C unchanged.
- R11: After reset, `done` and `busy` are low and A, B and C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` on the given operands |
| instr | input | 16 | Shift instruction word |
| a_in | input | 16 | Accumulator operand |
| b_in | input | 16 | Extension register operand |
| c_in | input | 1 | Carry flag operand |
| a_out | output | 16 | Resulting accumulator |
| b_out | output | 16 | Resulting extension register |
| c_out | output | 1 | Resulting carry flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Shift in progress |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse that never overlaps `busy`.
- Arithmetic right shifts keep the sign bit.
- Logical right shifts fill with zero.
- Rotates leave C alone.
- The carry of an arithmetic left shift, once set, stays set.
- Single forms never touch B.
- A start during a shift does not disturb it.
- An illegal code completes at once with A unchanged.

Only the bench's scenarios can show the rest:
- The final bit pattern of each of the twelve variants.
- The exact clock count for each amount, including the count field of zero that means 64.
- Which bit ends up in C.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         c_out,
  output logic         done,
  output logic         busy
);
  localparam int FW = W - CW;
  localparam int NW = CW + 1;
  localparam logic [FW-5:0] FAMILY = (FW-4)'(16);
  localparam logic [1:0] K_LOG = 2'd0, K_ARI = 2'd1, K_ROT = 2'd2;

  logic [FW-1:0] func;
  logic          legal;
  logic [NW-1:0] amount;

  assign func   = instr[W-1:CW];
  assign legal  = (func[FW-1:4] == FAMILY) && (func[1:0] != 2'b11);
  assign amount = NW'(2 ** CW) - NW'(instr[CW-1:0]);

  logic [W-1:0]  a_q, b_q, a_n, b_n;
  logic          c_q, c_n;
  logic [NW-1:0] rem_q;
  logic          left_q, single_q;
  logic [1:0]    kind_q;
  logic          fill;

  always_comb begin
    a_n = a_q;
    b_n = b_q;
    c_n = c_q;
    if (left_q) begin
      fill = (kind_q == K_ROT) ? a_q[W-1] : 1'b0;
      if (single_q) a_n = {a_q[W-2:0], fill};
      else          {a_n, b_n} = {a_q[W-2:0], b_q, fill};
      if (kind_q == K_ARI)      c_n = c_q | (a_q[W-1] ^ a_q[W-2]);
      else if (kind_q == K_LOG) c_n = a_q[W-1];
    end else begin
      if (kind_q == K_ARI)      fill = a_q[W-1];
      else if (kind_q == K_ROT) fill = single_q ? a_q[0] : b_q[0];
      else                      fill = 1'b0;
      if (single_q) a_n = {fill, a_q[W-1:1]};
      else          {a_n, b_n} = {fill, a_q, b_q[W-1:1]};
      if (kind_q != K_ROT) c_n = single_q ? a_q[0] : b_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= 1'b0;
      rem_q    <= '0;
      left_q   <= 1'b0;
      single_q <= 1'b0;
      kind_q   <= K_LOG;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        a_q   <= a_n;
        b_q   <= b_n;
        c_q   <= c_n;
        rem_q <= rem_q - 1'b1;
        if (rem_q == NW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        a_q      <= a_in;
        b_q      <= b_in;
        left_q   <= func[3];
        single_q <= func[2];
        kind_q   <= func[1:0];
        rem_q    <= amount;
        if (legal) begin
          busy <= 1'b1;
          c_q  <= (func[3] && func[1:0] == K_ARI) ? 1'b0 : c_in;
        end else begin
          c_q  <= c_in;
          done <= 1'b1;
        end
      end
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign c_out = c_q;

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (left_q == $past(left_q) && kind_q == $past(kind_q)
                         && rem_q == $past(rem_q) - 1'b1));
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !left_q && kind_q == K_LOG) |=> !a_q[W-1]);
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !left_q && kind_q == K_ARI) |=> a_q[W-1] == $past(a_q[W-1]));
  a_r7_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q && kind_q == K_ARI && c_q) |=> c_q);
  a_r8_rot_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_ROT) |=> $stable(c_q));
  a_r9_single_b: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && single_q) |=> $stable(b_q));
  a_r10_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !legal) |=> (done && a_q == $past(a_in) && b_q == $past(b_in)));
endmodule

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, a_in = '0, b_in = '0;
  logic        c_in = 1'b0;
  logic [15:0] a_out, b_out;
  logic        c_out, done, busy;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  shift_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .a_out(a_out), .b_out(b_out),
    .c_out(c_out), .done(done), .busy(busy));

  localparam int NV = 16;
  localparam logic [48:0] VEC [NV] = '{
    {10'o404, 6'd60, 16'h8421, 16'h1234, 1'b0},
    {10'o405, 6'd61, 16'h8001, 16'h5555, 1'b0},
    {10'o406, 6'd59, 16'h1235, 16'hAAAA, 1'b1},
    {10'o414, 6'd63, 16'h8000, 16'h0F0F, 1'b0},
    {10'o415, 6'd62, 16'h2000, 16'h0000, 1'b1},
    {10'o415, 6'd60, 16'h0003, 16'h0000, 1'b1},
    {10'o416, 6'd48, 16'hBEEF, 16'h1111, 1'b1},
    {10'o400, 6'd44, 16'hF00F, 16'h1234, 1'b0},
    {10'o401, 6'd56, 16'h8000, 16'h0001, 1'b0},
    {10'o402, 6'd28, 16'h1357, 16'h9BDF, 1'b0},
    {10'o410, 6'd47, 16'h4321, 16'h8765, 1'b1},
    {10'o411, 6'd61, 16'h1000, 16'h0000, 1'b0},
    {10'o412, 6'd0,  16'hCAFE, 16'hF00D, 1'b0},
    {10'o403, 6'd60, 16'h1111, 16'h2222, 1'b1},
    {10'o417, 6'd60, 16'h3333, 16'h4444, 1'b0},
    {10'o000, 6'd0,  16'h5555, 16'h6666, 1'b1}
  };

  function automatic logic [32:0] model(input logic [15:0] ins, a, b,
                                        input logic c, output int n);
    logic [9:0]  f;
    logic [31:0] v;
    logic        cc, o, s;
    f = ins[15:6];
    if (f[9:4] != 6'o20 || f[1:0] == 2'b11) begin
      n = 0;
      return {a, b, c};
    end
    n  = (ins[5:0] == 6'd0) ? 64 : 64 - int'(ins[5:0]);
    cc = (f[3] && f[1:0] == 2'd1) ? 1'b0 : c;
    for (int i = 0; i < n; i++) begin
      if (f[2]) begin
        s = a[15];
        if (f[3]) begin o = a[15]; a = {a[14:0], (f[1:0] == 2'd2) ? o : 1'b0}; end
        else begin o = a[0]; a = {(f[1:0] == 2'd2) ? o : (f[1:0] == 2'd1) ? s : 1'b0, a[15:1]}; end
      end else begin
        v = {a, b};
        s = v[31];
        if (f[3]) begin o = v[31]; v = {v[30:0], (f[1:0] == 2'd2) ? o : 1'b0}; end
        else begin o = v[0]; v = {(f[1:0] == 2'd2) ? o : (f[1:0] == 2'd1) ? s : 1'b0, v[31:1]}; end
        a = v[31:16];
        b = v[15:0];
      end
      if (f[1:0] == 2'd0) cc = o;
      else if (f[1:0] == 2'd1) cc = f[3] ? (cc | (s != a[15])) : o;
    end
    return {a, b, cc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [32:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, a, b, input logic c,
                     input logic [32:0] exp, input int en, input string req);
    int cyc;
    @(negedge clk);
    instr = ins; a_in = a; b_in = b; c_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == en, {req, " R2 latency"}, 33'(cyc), 33'(en));
    chk({a_out, b_out, c_out} == exp, req, {a_out, b_out, c_out}, exp);
    @(negedge clk);
    chk(!done && {a_out, b_out, c_out} == exp, "R3 hold after done",
        {a_out, b_out, c_out}, exp);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] e;
    int n;
    repeat (3) @(negedge clk);
    chk(!done && !busy && a_out == 0 && b_out == 0 && !c_out, "R11 reset",
        {a_out, b_out, c_out}, 33'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], n);
      run(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], e, n,
          "R1 R5 R6 R7 R8 R9 R10 vector");
    end

    run({10'o414, 6'd63}, 16'h8000, 16'h0F0F, 1'b0, {16'h0000, 16'h0F0F, 1'b1}, 1, "R5 lgl1");
    run({10'o415, 6'd62}, 16'h2000, 16'h0000, 1'b1, {16'h8000, 16'h0000, 1'b1}, 2, "R7 sign change");
    run({10'o415, 6'd60}, 16'h0003, 16'h0000, 1'b1, {16'h0030, 16'h0000, 1'b0}, 4, "R7 no change");
    run({10'o405, 6'd61}, 16'h8001, 16'h5555, 1'b0, {16'hF000, 16'h5555, 1'b0}, 3, "R6 ars3");
    run({10'o412, 6'd0}, 16'hCAFE, 16'hF00D, 1'b0, {16'hCAFE, 16'hF00D, 1'b0}, 64, "R2 R8 count zero");
    run({10'o400, 6'd48}, 16'h0001, 16'h0000, 1'b0, {16'h0000, 16'h0001, 1'b0}, 16, "R9 long crossing");
    run({10'o403, 6'd60}, 16'h1111, 16'h2222, 1'b1, {16'h1111, 16'h2222, 1'b1}, 0, "R10 illegal");

    @(negedge clk);
    instr = {10'o404, 6'd54}; a_in = 16'hFFFF; b_in = 16'h0000; c_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    instr = {10'o414, 6'd62}; a_in = 16'h1234; b_in = 16'h5678; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 4;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == 10, "R4 latency unchanged", 33'(n), 33'd10);
    chk({a_out, b_out, c_out} == {16'h003F, 16'h0000, 1'b1}, "R4 start ignored",
        {a_out, b_out, c_out}, {16'h003F, 16'h0000, 1'b1});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule